// File: doc/BRIEF.md
# Multi-Input Wake-Up Interrupt Controller

This block monitors seven general-purpose input pins and one receive line from a serial bus transceiver. Each pin passes through a synchronizer and an edge detector whose polarity software picks per pin. A qualifying edge sets that pin's bit in a sticky pending register. The pending bits, masked by a per-pin enable, drive one shared interrupt request. The same masked bits also drive a wake request that goes to the clock sequencer.

The interrupt is gated by two flags: a global interrupt enable and a port-level interrupt enable. The wake request ignores both flags, so a sleeping device can resume without taking an interrupt. The receive line is a separate wake source that is always armed. It reacts to a falling edge, produces only a one-cycle wake pulse, and has no pending bit, no enable and no interrupt.

Software uses a small synchronous register port to access the pin enable mask, the edge polarity, the pending bits (write one to clear) and the two enable flags.

Top module: `wkup_irq_ctrl`

## Requirements
- R1: After synchronous reset, all registers read zero, and `irq` and `wake` are low.
- R2: With polarity bit 0 (rising), a 0-to-1 change on a pin sets its pending bit on the third rising clock edge after the change. A 1-to-0 change on that pin sets nothing.
- R3: With polarity bit 1 (falling), a 1-to-0 change sets the pending bit and a 0-to-1 change does not.
- R4: A pending bit latches even while its enable bit is 0. A pending bit whose enable bit is 0 has no effect on `irq` or `wake`, and setting the enable later lets it take effect.
- R5: `irq` is high one cycle after the following three conditions hold together: control bit 0 (global enable) is 1, control bit 1 (port enable) is 1, and some pin has both its pending bit and its enable bit set. If either control bit is 0, `irq` stays low.
- R6: `wake` is high one cycle after some pin has both its pending bit and its enable bit set, whatever the values of the control bits.
- R7: A 1-to-0 change on `rx_in` makes `wake` high for exactly one cycle, on the third rising clock edge after the change. It never raises `irq` and sets no pending bit. A 0-to-1 change on `rx_in` does nothing.
- R8: Writing to the pending register clears every bit written as 1. Bits written as 0 keep their value.
- R9: If a qualifying edge on a pin is detected in the same cycle as a write-one-to-clear of that pin's pending bit, the bit stays set.
- R10: The register map is: address 0 is the enable mask, address 1 is the polarity, address 2 is the pending bits, and address 3 is the control register (bit 0 global enable, bit 1 port enable). Pin n maps to bit n. Unused bits read as 0. Addresses 4 to 7 read as 0 and ignore writes. `reg_rdata` shows the register selected by `reg_addr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 7 | Asynchronous wake/interrupt pins |
| rx_in | input | 1 | Bus receive line, idles high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Shared port interrupt request |
| wake | output | 1 | Wake request to the clock sequencer |

## Verification
Two events can land on the same pending flip-flop in the same cycle: a new edge from the synchronizer, and a software write-one-to-clear. The bench first latches a pin's bit and returns the pin to its idle level. It then drives the pin again and times the clear so that the write is sampled on the same clock edge that captures the detected edge. A read-back is then expected to show the bit still set. A plain clear with no edge is run alongside it and must leave the bit at 0.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADR_MASK = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_POL  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_PEND = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd3;
  localparam int CTRL_GIE = 0;
  localparam int CTRL_PIE = 1;
endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[b]}};
        else     chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/wkup_edge.sv
module wkup_edge #(
  parameter int               WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] fall_sel,
  output logic [WIDTH-1:0] evt
);
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= cur;
  end

  // per bit: falling when selected, rising otherwise
  assign evt = (fall_sel & prev & ~cur) | (~fall_sel & ~prev & cur);
endmodule

// File: rtl/wkup_regs.sv
module wkup_regs
  import wkup_pkg::*;
#(
  parameter int NUM_PINS = 7,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_PINS-1:0] pin_evt,
  output logic [NUM_PINS-1:0] mask,
  output logic [NUM_PINS-1:0] fall_sel,
  output logic [NUM_PINS-1:0] pend,
  output logic                gie,
  output logic                pie,
  output logic [DATA_W-1:0]   rdata
);
  logic [NUM_PINS-1:0] clr_vec;
  logic [DATA_W-1:0]   rd_mux;
  logic                unused_wdata;

  assign unused_wdata = ^wdata;
  assign clr_vec = (wr && addr == ADR_PEND) ? wdata[NUM_PINS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask     <= '0;
      fall_sel <= '0;
      gie      <= 1'b0;
      pie      <= 1'b0;
    end else if (wr) begin
      if (addr == ADR_MASK) mask     <= wdata[NUM_PINS-1:0];
      if (addr == ADR_POL)  fall_sel <= wdata[NUM_PINS-1:0];
      if (addr == ADR_CTRL) begin
        gie <= wdata[CTRL_GIE];
        pie <= wdata[CTRL_PIE];
      end
    end
  end

  // edge set dominates a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr_vec) | pin_evt;
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADR_MASK: rd_mux[NUM_PINS-1:0] = mask;
      ADR_POL:  rd_mux[NUM_PINS-1:0] = fall_sel;
      ADR_PEND: rd_mux[NUM_PINS-1:0] = pend;
      ADR_CTRL: begin
        rd_mux[CTRL_GIE] = gie;
        rd_mux[CTRL_PIE] = pie;
      end
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/wkup_irq_ctrl.sv
module wkup_irq_ctrl
  import wkup_pkg::*;
#(
  parameter int NUM_PINS    = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                rx_in,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq,
  output logic                wake
);
  logic [NUM_PINS-1:0] pin_sync_w;
  logic [NUM_PINS-1:0] pin_evt_w;
  logic [NUM_PINS-1:0] mask_w;
  logic [NUM_PINS-1:0] fall_w;
  logic [NUM_PINS-1:0] pend_w;
  logic                gie_w;
  logic                pie_w;
  logic                rx_sync_w;
  logic                rx_fall_w;
  logic                armed_w;

  wkup_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync_w)
  );

  wkup_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
    .clk(clk), .rst(rst), .d(rx_in), .q(rx_sync_w)
  );

  wkup_edge #(.WIDTH(NUM_PINS), .RST_VAL('0)) u_pin_edge (
    .clk(clk), .rst(rst), .cur(pin_sync_w), .fall_sel(fall_w), .evt(pin_evt_w)
  );

  wkup_edge #(.WIDTH(1), .RST_VAL(1'b1)) u_rx_edge (
    .clk(clk), .rst(rst), .cur(rx_sync_w), .fall_sel(1'b1), .evt(rx_fall_w)
  );

  wkup_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .pin_evt(pin_evt_w), .mask(mask_w), .fall_sel(fall_w), .pend(pend_w),
    .gie(gie_w), .pie(pie_w), .rdata(reg_rdata)
  );

  assign armed_w = |(pend_w & mask_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq  <= 1'b0;
      wake <= 1'b0;
    end else begin
      irq  <= gie_w & pie_w & armed_w;
      wake <= armed_w | rx_fall_w;
    end
  end
endmodule

// File: rtl/wkup_irq_ctrl_chk.sv
module wkup_irq_ctrl_chk #(
  parameter int NUM_PINS = 7,
  parameter int DATA_W   = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                irq,
  input logic                wake,
  input logic                reg_wr,
  input logic [2:0]          reg_addr,
  input logic [DATA_W-1:0]   reg_wdata,
  input logic [NUM_PINS-1:0] pend,
  input logic [NUM_PINS-1:0] evt
);
  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> (!irq && !wake)); // R1

  AST_IRQ_IMPLIES_WAKE: assert property (@(posedge clk) disable iff (rst)
    irq |-> wake); // R6

  AST_PEND_DROP_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    (|($past(pend) & ~pend)) |-> ($past(reg_wr) && $past(reg_addr) == 3'd2)); // R8

  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !(|($past(evt) & ~pend))); // R9
endmodule

bind wkup_irq_ctrl wkup_irq_ctrl_chk #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .wake(wake), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pend(pend_w), .evt(pin_evt_w)
);

// File: tb/wkup_irq_ctrl_bench.sv
`timescale 1ns/1ps
module wkup_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] pin_in = '0;
  logic       rx_in = 1'b1;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, wake;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  string      tq[$];
  int         sq[$];
  logic [7:0] eq[$];

  always #2.5 clk = ~clk;

  wkup_irq_ctrl u_wkup_irq_ctrl (
    .clk(clk), .rst(rst), .pin_in(pin_in), .rx_in(rx_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .wake(wake)
  );

  // monitor: compares queued expectations in the cycle they were posted
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sq.size() > 0) begin
        string      t;
        int         s;
        logic [7:0] e, a;
        t = tq.pop_front(); s = sq.pop_front(); e = eq.pop_front();
        a = (s == 0) ? {7'd0, irq} : (s == 1) ? {7'd0, wake} : reg_rdata;
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s actual=%0h expected=%0h", t, a, e);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic expect_out(input int sel, input logic [7:0] e, input string t);
    tq.push_back(t); sq.push_back(sel); eq.push_back(e);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    reg_addr = a;
    step(1);
    expect_out(2, e, t);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(4);
    rst = 1'b0;
    step(1);
    expect_out(0, 8'h0, "R1 irq after reset");
    expect_out(1, 8'h0, "R1 wake after reset");
    rd(3'd0, 8'h00, "R1 mask reset");
    rd(3'd1, 8'h00, "R1 polarity reset");
    rd(3'd2, 8'h00, "R1 pending reset");
    rd(3'd3, 8'h00, "R1 control reset");

    // basic rising edge on pin0
    wr(3'd0, 8'h7F);
    wr(3'd3, 8'h03);
    rd(3'd3, 8'h03, "R10 control readback");
    reg_addr = 3'd2;
    pin_in[0] = 1'b1;
    step(3);
    expect_out(0, 8'h0, "R5 irq not before latency");
    step(1);
    expect_out(0, 8'h1, "R5 irq raised");
    expect_out(1, 8'h1, "R6 wake raised");
    expect_out(2, 8'h01, "R2 pending bit0 via rdata");

    // clear semantics
    wr(3'd2, 8'h00);
    rd(3'd2, 8'h01, "R8 zero write keeps bit");
    wr(3'd2, 8'h01);
    step(1);
    expect_out(0, 8'h0, "R8 irq dropped after clear");
    rd(3'd2, 8'h00, "R8 bit cleared");
    pin_in[0] = 1'b0;
    step(5);
    rd(3'd2, 8'h00, "R2 falling ignored under rising polarity");

    // falling polarity on pin1
    wr(3'd1, 8'h02);
    pin_in[1] = 1'b1;
    step(5);
    rd(3'd2, 8'h00, "R3 rising ignored under falling polarity");
    pin_in[1] = 1'b0;
    step(5);
    rd(3'd2, 8'h02, "R3 falling latched");
    wr(3'd2, 8'h7F);

    // disabled pin latches but is masked
    wr(3'd0, 8'h7B);
    pin_in[2] = 1'b1;
    step(5);
    expect_out(0, 8'h0, "R4 masked pin no irq");
    expect_out(1, 8'h0, "R4 masked pin no wake");
    rd(3'd2, 8'h04, "R4 masked pin still pending");
    wr(3'd0, 8'h7F);
    step(1);
    expect_out(0, 8'h1, "R4 irq after enabling");
    wr(3'd2, 8'h7F);
    step(1);

    // enable flags gate irq, not wake
    wr(3'd3, 8'h02);
    pin_in[3] = 1'b1;
    step(5);
    expect_out(0, 8'h0, "R5 irq low with global off");
    expect_out(1, 8'h1, "R6 wake regardless of flags");
    wr(3'd3, 8'h01);
    step(1);
    expect_out(0, 8'h0, "R5 irq low with port flag off");
    wr(3'd3, 8'h03);
    step(1);
    expect_out(0, 8'h1, "R5 irq with both flags");
    wr(3'd2, 8'h7F);
    step(2);
    expect_out(1, 8'h0, "R6 wake released");

    // rx falling wake
    rx_in = 1'b0;
    step(3);
    expect_out(1, 8'h1, "R7 rx wake pulse");
    expect_out(0, 8'h0, "R7 rx no irq");
    step(1);
    expect_out(1, 8'h0, "R7 rx pulse one cycle");
    rd(3'd2, 8'h00, "R7 rx no pending");
    rx_in = 1'b1;
    step(3);
    expect_out(1, 8'h0, "R7 rx rising ignored");

    // same-cycle edge and clear on pin4
    pin_in[4] = 1'b1;
    step(5);
    pin_in[4] = 1'b0;
    step(5);
    rd(3'd2, 8'h10, "R9 setup pending bit4");
    pin_in[4] = 1'b1;
    step(2);
    wr(3'd2, 8'h10);
    rd(3'd2, 8'h10, "R9 edge wins over clear");
    wr(3'd2, 8'h10);
    rd(3'd2, 8'h00, "R9 plain clear afterwards");

    // unmapped addresses
    wr(3'd5, 8'hFF);
    rd(3'd5, 8'h00, "R10 unmapped reads zero");
    rd(3'd0, 8'h7F, "R10 mask untouched");
    rd(3'd1, 8'h02, "R10 polarity untouched");
    rd(3'd3, 8'h03, "R10 control untouched");

    step(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule